// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that must be serviced inside a time window. It holds a 7-bit down-counter that steps once per timebase tick. The tick comes from the peripheral clock through a fixed prescaler, 4096 by default, followed by a selectable divide by 1, 2, 4 or 8. Software starts the watchdog by setting an enable bit. After that it must reload the counter regularly. A reload is accepted only once the counter has fallen below a programmed window value and while counter bit 6 is still set. A reload that comes too early requests a system reset at once. A counter that falls through 0x40 also requests a reset.

An early-warning flag is raised one step before expiry. It can drive an interrupt, so that software gets a last chance to reload. A debug freeze input stops the count while a halted core is being inspected. Software reaches the block through a simple synchronous register bus with three registers:

- Address 0 is the control register.
- Address 1 is the configuration register.
- Address 2 is the status register.

Top module: `wdw_top`

## Requirements
- R1: After reset the watchdog is disabled, and the system reset request and the interrupt are low. A read of address 0 returns 0x007F (counter 0x7F, enable bit 7 clear). Address 1 returns 0x007F (window 0x7F in bits 6:0, timebase 0 in bits 8:7, interrupt enable bit 9 clear). Address 2 returns 0. Address 3 returns 0.
- R2: While enabled and not frozen, the counter decrements once every PRESCALE × 2^tb clock cycles, where tb is configuration bits 8:7. While disabled the counter holds its value.
- R3: Writing 1 to control bit 7 enables the watchdog. Writing 0 to that bit has no effect, and only the block reset clears the enable.
- R4: Every write to address 0 loads the counter with write-data bits 6:0. A load takes priority over a decrement in the same cycle.
- R5: When an enabled counter decrements from 0x40 to 0x3F, `rst_req` is high for exactly the one cycle that follows that clock edge.
- R6: A write to address 0 while enabled, made when the counter is above the window value (configuration bits 6:0), raises `rst_req` on that clock edge. A write made while the counter is at or below the window is accepted without a reset.
- R7: With the window set to 0x7F, a reload is accepted at any counter value.
- R8: A write to address 0 that leaves the watchdog enabled and carries write-data bit 6 = 0 raises `rst_req` on that clock edge. This includes the write that enables it.
- R9: The early-warning flag (status bit 0) is set on the clock edge at which a decrement brings the counter to 0x40.
- R10: `ew_irq` is high exactly while the early-warning flag is set and configuration bit 9 is 1.
- R11: Writing 0 to status bit 0 clears the flag. Writing 1 leaves it unchanged.
- R12: While `freeze` is high, neither the counter nor the tick divider advances. Counting resumes from the held phase when `freeze` is released.
- R13: The tick divider restarts from zero on the write that first enables the watchdog, so the first decrement falls PRESCALE × 2^tb cycles after that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| freeze | input | 1 | Debug freeze: high stops the count |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 control, 1 configuration, 2 status) |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational from address) |
| rst_req | output | 1 | One-cycle system reset request |
| ew_irq | output | 1 | Early-warning interrupt |

## Verification
The bench instantiates the block with PRESCALE = 4 and keeps the default counter, timebase and data widths. At that setting a full countdown from 0x7F takes a few hundred cycles instead of hundreds of thousands. Every expiry, window violation and early-warning edge can therefore be checked to the exact cycle. Timebase settings 0 and 2 are both used, so the selectable divider is seen scaling the tick period. Reloads are placed relative to the known tick grid, which reaches both the accepted and the rejected side of the window.

// File: rtl/wdw_pkg.sv
// Package: shared register addresses and field positions for the windowed watchdog.
// Assumes the counter is 7 bits and the timebase field is 2 bits wide (defaults of wdw_top).
package wdw_pkg;
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_CFG  = 2'd1,
        REG_STAT = 2'd2,
        REG_NONE = 2'd3
    } wdw_reg_e;

    localparam int STAT_FLAG_BIT = 0;
endpackage

// File: rtl/wdw_tickgen.sv
// Module: wdw_tickgen
// Produces a one-cycle tick every PRESCALE * 2^tb_sel cycles while run is high and
// freeze is low. restart clears both stages. Assumes PRESCALE >= 2.
module wdw_tickgen #(
    parameter int PRESCALE = 4096,
    parameter int TB_W     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            run,
    input  logic            freeze,
    input  logic [TB_W-1:0] tb_sel,
    output logic            tick
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam int DIV_W = (1 << TB_W) - 1;

    logic [PRE_W-1:0] pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W:0]   div_lim;
    logic             active;
    logic             pre_last;
    logic             div_last;

    // Decode stage limits and the pause condition.
    always_comb begin
        active   = run && !freeze;
        pre_last = (pre_cnt == PRE_W'(PRESCALE - 1));
        div_lim  = ((DIV_W+1)'(1) << tb_sel) - (DIV_W+1)'(1);
        div_last = ({1'b0, div_cnt} == div_lim);
        tick     = active && pre_last && div_last;
    end

    // Advance the fixed prescaler, then the selectable divider.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (active) begin
            if (pre_last) begin
                pre_cnt <= '0;
                div_cnt <= div_last ? '0 : div_cnt + DIV_W'(1);
            end else begin
                pre_cnt <= pre_cnt + PRE_W'(1);
            end
        end
    end
endmodule

// File: rtl/wdw_counter.sv
// Module: wdw_counter
// The down-counter. A load wins over a tick. It flags the step into the warning
// value (MSB-only) and the step out of it (expiry). Assumes tick is only given while enabled.
module wdw_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             ew_set,
    output logic             expire
);
    localparam logic [CNT_W-1:0] WARN_VAL = CNT_W'(1) << (CNT_W - 1);

    logic dec;

    // Classify the current step.
    always_comb begin
        dec    = tick && !load;
        ew_set = dec && (cnt == WARN_VAL + CNT_W'(1));
        expire = dec && (cnt == WARN_VAL);
    end

    // Load or decrement the counter.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '1;
        else if (load)   cnt <= load_val;
        else if (dec)    cnt <= cnt - CNT_W'(1);
    end
endmodule

// File: rtl/wdw_top.sv
// Module: wdw_top
// Windowed watchdog: register decode, sticky enable, window and reload checks,
// early-warning flag and reset request. Assumes DATA_W >= CNT_W + TB_W + 1.
module wdw_top
    import wdw_pkg::*;
#(
    parameter int PRESCALE = 4096,
    parameter int CNT_W    = 7,
    parameter int TB_W     = 2,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freeze,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req,
    output logic              ew_irq
);
    localparam int EN_BIT  = CNT_W;
    localparam int TB_LSB  = CNT_W;
    localparam int EWI_BIT = CNT_W + TB_W;

    logic             en;
    logic [CNT_W-1:0] win;
    logic [TB_W-1:0]  tb;
    logic             ewi_en;
    logic             flag;
    logic [CNT_W-1:0] cnt;
    logic             tick;
    logic             ew_set;
    logic             expire;
    logic             ctrl_wr;
    logic             cfg_wr;
    logic             stat_wr;
    logic             start;
    logic             en_after;
    logic             violation;

    // Decode writes and the reload-legality checks.
    always_comb begin
        ctrl_wr   = bus_we && (bus_addr == REG_CTRL);
        cfg_wr    = bus_we && (bus_addr == REG_CFG);
        stat_wr   = bus_we && (bus_addr == REG_STAT);
        start     = ctrl_wr && bus_wdata[EN_BIT] && !en;
        en_after  = en || (ctrl_wr && bus_wdata[EN_BIT]);
        violation = ctrl_wr && ((en && (cnt > win)) ||
                                (en_after && !bus_wdata[CNT_W-1]));
    end

    // Sticky enable: set by software, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     en <= 1'b0;
        else if (start) en <= 1'b1;
    end

    // Configuration register fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win    <= '1;
            tb     <= '0;
            ewi_en <= 1'b0;
        end else if (cfg_wr) begin
            win    <= bus_wdata[CNT_W-1:0];
            tb     <= bus_wdata[TB_LSB +: TB_W];
            ewi_en <= bus_wdata[EWI_BIT];
        end
    end

    // Early-warning flag: set by hardware, cleared by writing zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   flag <= 1'b0;
        else if (ew_set)                              flag <= 1'b1;
        else if (stat_wr && !bus_wdata[STAT_FLAG_BIT]) flag <= 1'b0;
    end

    // Single-cycle reset request on expiry or on an illegal reload.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= expire || violation;
    end

    // Drive the interrupt output.
    always_comb ew_irq = flag && ewi_en;

    // Read mux with live values.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CTRL: bus_rdata[CNT_W:0] = {en, cnt};
            REG_CFG:  bus_rdata[EWI_BIT:0] = {ewi_en, tb, win};
            REG_STAT: bus_rdata[STAT_FLAG_BIT] = flag;
            default:  bus_rdata = '0;
        endcase
    end

    wdw_tickgen #(.PRESCALE(PRESCALE), .TB_W(TB_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(start), .run(en),
        .freeze(freeze), .tb_sel(tb), .tick(tick)
    );

    wdw_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(ctrl_wr), .load_val(bus_wdata[CNT_W-1:0]),
        .tick(tick), .cnt(cnt), .ew_set(ew_set), .expire(expire)
    );
endmodule

// File: rtl/wdw_checker.sv
// Module: wdw_checker
// Temporal properties of wdw_top, attached through bind. Observes internal nets of the top.
module wdw_checker #(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             freeze,
    input logic             ctrl_wr,
    input logic             en,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic             flag,
    input logic             rst_req
);
    localparam logic [CNT_W-1:0] WARN_VAL = CNT_W'(1) << (CNT_W - 1);

    AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> en);                                                   // R3
    AST_NO_TICK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !tick);                                               // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ctrl_wr) |=> $stable(cnt));                        // R4
    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !ctrl_wr) |=> $stable(cnt));                       // R12
    AST_EXPIRE_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ctrl_wr && cnt == WARN_VAL) |=> rst_req);           // R5
    AST_FLAG_AT_WARN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> (cnt == WARN_VAL));                           // R9
endmodule

bind wdw_top wdw_checker #(.CNT_W(CNT_W)) u_wdw_chk (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .ctrl_wr(ctrl_wr), .en(en),
    .tick(tick), .cnt(cnt), .flag(flag), .rst_req(rst_req)
);

// File: tb/wdw_top_bench.sv
// Bench for wdw_top. Scenario tasks push expected reset-pulse cycles into a queue,
// and a monitor pops and compares each pulse as it appears.
module wdw_top_bench;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        freeze = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        rst_req;
    logic        ew_irq;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int exp_cyc[$];
    string exp_tag[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdw_top #(.PRESCALE(P)) u_wdw_top (
        .clk(clk), .rst_n(rst_n), .freeze(freeze), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req), .ew_irq(ew_irq)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    task automatic push_exp(input int c, input string tag);
        exp_cyc.push_back(c);
        exp_tag.push_back(tag);
    endtask

    // Monitor: every reset pulse must match the head of the expectation queue.
    always @(negedge clk) begin
        if (rst_n && rst_req) begin
            if (exp_cyc.size() == 0) begin
                check("R6 unexpected rst_req", 1, 0);
            end else begin
                check(exp_tag.pop_front(), cyc, exp_cyc.pop_front());
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d, output int edge_no);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        edge_no = cyc + 1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        bus_we = 1'b0; bus_addr = a;
        #1 d = int'(bus_rdata);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        check("R5 pending pulses before reset", exp_cyc.size(), 0);
        rst_n = 1'b0; freeze = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic int next_pulse(int e, int l, int t, int v);
        int f = e + t * ((l - e) / t + 1);
        return f + t * (v - 64);
    endfunction

    task automatic run_all();
        int e, l, v, a;
        do_reset();
        // R1 reset state, R2 hold while disabled
        rd(2'd0, v); check("R1 ctrl", v, 16'h007F);
        rd(2'd1, v); check("R1 cfg", v, 16'h007F);
        rd(2'd2, v); check("R1 stat", v, 0);
        rd(2'd3, v); check("R1 unused", v, 0);
        check("R1 rst_req", rst_req, 0);
        check("R1 ew_irq", ew_irq, 0);
        repeat (20) @(negedge clk);
        rd(2'd0, v); check("R2 hold while disabled", v, 16'h007F);

        // R2/R13/R5/R9 timebase 0
        do_reset();
        wr(2'd1, 16'h007F, l);
        repeat (3) @(negedge clk);
        push_exp(cyc + 1 + P * (8'h45 - 8'h3F), "R5 expiry tb0");
        wr(2'd0, 16'h00C5, e);
        wait_until(e + 3); rd(2'd0, v); check("R13 first step not early", v, 16'h00C5);
        wait_until(e + 8); rd(2'd0, v); check("R2 two ticks tb0", v, 16'h00C3);
        wait_until(e + 19); rd(2'd2, v); check("R9 flag before 0x40", v, 0);
        wait_until(e + 20); rd(2'd2, v); check("R9 flag at 0x40", v, 1);
        check("R10 irq masked", ew_irq, 0);
        wait_until(e + 26);
        check("R5 pulse seen", exp_cyc.size(), 0);

        // R2 timebase 2
        do_reset();
        wr(2'd1, 16'h017F, l);
        push_exp(cyc + 1 + 16 * 3, "R2 expiry tb2");
        wr(2'd0, 16'h00C2, e);
        wait_until(e + 15); rd(2'd0, v); check("R2 tb2 before tick", v, 16'h00C2);
        wait_until(e + 16); rd(2'd0, v); check("R2 tb2 at tick", v, 16'h00C1);
        wait_until(e + 50);

        // R6 early reload
        do_reset();
        wr(2'd1, 16'h0050, l);
        wr(2'd0, 16'h00FF, e);
        push_exp(cyc + 1, "R6 reload above window");
        wr(2'd0, 16'h007F, l);
        wait_until(l + 2);
        check("R6 pulse seen", exp_cyc.size(), 0);

        // R6 reload inside window accepted
        do_reset();
        wr(2'd1, 16'h0050, l);
        wr(2'd0, 16'h00D2, e);
        wait_until(e + 13);
        rd(2'd0, v); check("R6 counter below window", v, 16'h00CF);
        push_exp(next_pulse(e, cyc + 1, P, 8'h7F), "R6 legal reload expiry");
        wr(2'd0, 16'h007F, l);
        rd(2'd0, v); check("R4 reload value", v, 16'h00FF);
        wait_until(next_pulse(e, l, P, 8'h7F) + 2);

        // R7 open window, R3 enable write of 0 ignored
        do_reset();
        wr(2'd1, 16'h007F, l);
        wr(2'd0, 16'h00FF, e);
        wait_until(e + 4);
        push_exp(next_pulse(e, cyc + 1, P, 8'h70), "R7 reload at 0x7E accepted");
        wr(2'd0, 16'h0070, l);
        rd(2'd0, v); check("R3 enable kept after writing 0", v, 16'h00F0);
        wait_until(next_pulse(e, l, P, 8'h70) + 2);

        // R8 bit 6 clear while running, and on the enabling write
        do_reset();
        wr(2'd0, 16'h00FF, e);
        push_exp(cyc + 1, "R8 reload with bit6 clear");
        wr(2'd0, 16'h0030, l);
        wait_until(l + 2);
        do_reset();
        push_exp(cyc + 1, "R8 enabling write with bit6 clear");
        wr(2'd0, 16'h0085, l);
        wait_until(l + 2);

        // R10/R11 interrupt and flag clearing
        do_reset();
        wr(2'd1, 16'h027F, l);
        push_exp(cyc + 1 + P * 4, "R5 expiry with irq");
        wr(2'd0, 16'h00C3, e);
        wait_until(e + 11); check("R10 irq before flag", ew_irq, 0);
        wait_until(e + 12); check("R10 irq with flag", ew_irq, 1);
        wr(2'd2, 16'h0001, l);
        rd(2'd2, v); check("R11 writing 1 keeps flag", v, 1);
        wr(2'd2, 16'h0000, l);
        rd(2'd2, v); check("R11 writing 0 clears flag", v, 0);
        check("R10 irq follows flag", ew_irq, 0);
        wait_until(e + 18);

        // R12 freeze
        do_reset();
        wr(2'd0, 16'h00FF, e);
        wait_until(e + 6);
        freeze = 1'b1;
        rd(2'd0, a);
        repeat (20) @(negedge clk);
        rd(2'd0, v); check("R12 frozen counter", v, a);
        freeze = 1'b0;
        repeat (12) @(negedge clk);
        rd(2'd0, v); check("R12 resumes after release", int'(v < a), 1);
        do_reset();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                fails++;
                $display("FAIL R2 watchdog expired actual=running expected=done");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule